// File: doc/BRIEF.md
# Four-Lane PMA/PMD Management Register Bank

This block holds the management registers of a four-lane 10-gigabit PMA/PMD sublayer. A register port carrying a device address, a 16-bit register address, write data and separate read and write strobes reaches it; the serial management frame decoder sits outside and drives these strobes. Four registers are implemented: a second status word with fixed capability bits and two sticky fault flags, a transmit-disable control word, a signal-detect status word and an extended capability word.

The transmit-disable word and the transmit on/off pin together gate each lane's transmitter. The mode pin decides which lane output the gate acts on: the external optical-module enable in long-wavelength mode, or the differential copper driver enable in copper mode. The same mode pin selects the source of the per-lane signal-detect bits. The fault flags latch on single-cycle fault pulses. They clear when the status word is read, and also when either of two alarm-status addresses handled elsewhere in the device is read.

Top module: `pma_regbank`

## Requirements
- R1: A read of device 1, register 0x0008 returns bit 4 = 1 and bit 0 = 1. Bits 15:12, 9:6, 5, 3, 2 and 1 return 0. Bit 11 is the transmit fault flag and bit 10 is the receive fault flag.
- R2: A one-cycle pulse on `fault_evt[0]` (receive) or `fault_evt[1]` (transmit) sets the matching flag, which then stays 1 while no clearing read occurs.
- R3: A read of 0x0008 returns the flags as they stood before the read edge and clears them at that edge. A fault pulse in the same cycle as the clearing read leaves its flag set.
- R4: A read of device 1, register 0x9003 or 0x9004 clears both fault flags. These two reads return 0 from this block.
- R5: Register 0x0009 is read/write in bits 4:0: bit n+1 disables lane n, and bit 0 disables all lanes. Bits 15:5 always read 0. Reset value is 0.
- R6: A lane's transmit gate is open only when its own disable bit is 0, the global disable bit is 0 and `tx_on` is 1.
- R7: When `lx4_mode` = 1 the gate drives `lane_tx_en` and `lane_drv_en` stays all 1. When `lx4_mode` = 0 the gate drives `lane_drv_en` and `lane_tx_en` stays all 1.
- R8: Register 0x000A is read-only. Bit n+1 is lane n's detect, taken as NOT `opt_los[n]` when `lx4_mode` = 1 and as `cx4_sd[n]` when `lx4_mode` = 0. Bit 0 is the AND of the four lane bits, and bits 15:5 read 0.
- R9: Register 0x000B is read-only and reads 0x0001.
- R10: Reads of any other address, and any read with a device address other than 1, return 0. Writes anywhere except device 1, register 0x0009 change nothing.
- R11: `reg_rdata` is loaded on the clock edge that samples `reg_rd` = 1 and holds its value while `reg_rd` is 0.
- R12: A synchronous reset (`rst_n` = 0) clears the transmit-disable bits, the fault flags and `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_dev | input | 5 | Device address of the access |
| reg_addr | input | 16 | Register address of the access |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| lx4_mode | input | 1 | 1 = long-wavelength optical mode, 0 = copper mode |
| tx_on | input | 1 | Transmit on/off pin; 0 forces every lane off |
| opt_los | input | 4 | Per-lane optical loss-of-signal, 1 = no light |
| cx4_sd | input | 4 | Per-lane copper signal detect, 1 = signal present |
| fault_evt | input | 2 | Fault pulses: bit 0 receive, bit 1 transmit |
| lane_tx_en | output | 4 | Per-lane external transmit enable (optical mode) |
| lane_drv_en | output | 4 | Per-lane differential driver enable (copper mode) |
| reg_rdata | output | 16 | Registered read data |

## Verification
The hardest case to reach is a fault pulse that lands in exactly the cycle of a clearing read, whether the read is of the status word or of an alarm address. Random traffic seldom lines these up, so directed sequences place the pulse on the read cycle and then read the word again to confirm the flag survived. The random phase adds sparse fault pulses on top of a dense read mix, so the same collision also occurs with both flags and with both alarm addresses.

// File: rtl/pma_regbank_pkg.sv
// Package: shared widths, register addresses and bit positions of the
// PMA/PMD management register bank. Assumes a four-lane device.
package pma_regbank_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 16;
    localparam int DEV_W  = 5;
    localparam int NFLT   = 2;

    localparam logic [ADDR_W-1:0] ADR_STAT2  = 16'h0008;
    localparam logic [ADDR_W-1:0] ADR_TXDIS  = 16'h0009;
    localparam logic [ADDR_W-1:0] ADR_SIGDET = 16'h000A;
    localparam logic [ADDR_W-1:0] ADR_EXTCAP = 16'h000B;
    localparam logic [ADDR_W-1:0] ADR_ALM_A  = 16'h9003;
    localparam logic [ADDR_W-1:0] ADR_ALM_B  = 16'h9004;

    // Fault flag positions inside the second status word
    localparam int FLT_RX_BIT = 10;
    localparam int FLT_TX_BIT = 11;
    // Fixed capability bits that read 1
    localparam int CAP_LX4_BIT  = 4;
    localparam int CAP_LOOP_BIT = 0;
    localparam int CAP_CX4_BIT  = 0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT2,
        SEL_TXDIS,
        SEL_SIGDET,
        SEL_EXTCAP,
        SEL_ALARM
    } reg_sel_e;
endpackage

// File: rtl/pma_fault_latch.sv
// Sticky fault flags. Each flag sets on its event pulse and clears on
// the shared clear strobe; set wins over clear in the same cycle.
// Assumes event pulses are synchronous to clk.
module pma_fault_latch #(
    parameter int NBITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] set_evt,
    input  logic             clr,
    output logic [NBITS-1:0] flags
);
    for (genvar i = 0; i < NBITS; i++) begin : g_flag
        // Hold, set or clear one flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set_evt[i])
                flags[i] <= 1'b1;
            else if (clr)
                flags[i] <= 1'b0;
        end

        // R2
        flt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> flags[i]);
        // R3
        flt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !set_evt[i]) |=> !flags[i]);
    end
endmodule

// File: rtl/pma_txdis_ctrl.sv
// Transmit-disable control word and per-lane transmit gating. Bit 0 of
// the word disables all lanes, bit n+1 disables lane n. The gate drives
// the optical enable or the copper driver enable as the mode selects.
// Assumes wr_en is already qualified by device and address decode.
module pma_txdis_ctrl #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LANES:0]   wdata,
    input  logic             tx_on,
    input  logic             lx4_mode,
    output logic [LANES:0]   dis_q,
    output logic [LANES-1:0] lane_tx_en,
    output logic [LANES-1:0] lane_drv_en
);
    logic [LANES-1:0] lane_ok;

    // Store the control word on a qualified write
    always_ff @(posedge clk) begin
        if (!rst_n)
            dis_q <= '0;
        else if (wr_en)
            dis_q <= wdata;
    end

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        // Combine lane bit, global bit and pin for one lane
        always_comb lane_ok[n] = !dis_q[n+1] && !dis_q[0] && tx_on;
    end

    // Route the gate to the output the mode uses
    always_comb begin
        if (lx4_mode) begin
            lane_tx_en  = lane_ok;
            lane_drv_en = '1;
        end else begin
            lane_tx_en  = '1;
            lane_drv_en = lane_ok;
        end
    end

    // R5
    txdis_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> dis_q == $past(wdata));
    // R6
    pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_on |-> ((lane_tx_en & lane_drv_en) == '0));
    // R7
    mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lx4_mode |-> lane_drv_en == '1);
endmodule

// File: rtl/pma_sigdet.sv
// Signal-detect source selection. Optical mode inverts the loss-of-signal
// inputs; copper mode passes the copper detect through. Global detect is
// the AND of all lanes. Purely combinational.
module pma_sigdet #(
    parameter int LANES = 4
) (
    input  logic             lx4_mode,
    input  logic [LANES-1:0] opt_los,
    input  logic [LANES-1:0] cx4_sd,
    output logic [LANES-1:0] lane_sd,
    output logic             glob_sd
);
    for (genvar n = 0; n < LANES; n++) begin : g_sd
        // Pick this lane's detect source
        always_comb lane_sd[n] = lx4_mode ? !opt_los[n] : cx4_sd[n];
    end

    // Global detect needs every lane
    always_comb glob_sd = &lane_sd;
endmodule

// File: rtl/pma_regbank.sv
// Top of the PMA/PMD management register bank. Decodes the register
// port, assembles read words, registers read data and drives the
// fault-clear strobe. Assumes one-cycle rd/wr strobes from an external
// frame decoder.
module pma_regbank
    import pma_regbank_pkg::*;
#(
    parameter int                LANES  = 4,
    parameter logic [DEV_W-1:0]  DEV_ID = 5'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  reg_dev,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic              lx4_mode,
    input  logic              tx_on,
    input  logic [LANES-1:0]  opt_los,
    input  logic [LANES-1:0]  cx4_sd,
    input  logic [NFLT-1:0]   fault_evt,
    output logic [LANES-1:0]  lane_tx_en,
    output logic [LANES-1:0]  lane_drv_en,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int CTL_W = LANES + 1;

    logic              dev_hit;
    reg_sel_e          sel;
    logic              flt_clr;
    logic [NFLT-1:0]   flt_q;
    logic [CTL_W-1:0]  dis_q;
    logic [LANES-1:0]  lane_sd;
    logic              glob_sd;
    logic [DATA_W-1:0] rd_word;

    // Device match
    always_comb dev_hit = (reg_dev == DEV_ID);

    // Address decode to a register select
    always_comb begin
        sel = SEL_NONE;
        if (dev_hit) begin
            unique case (reg_addr)
                ADR_STAT2:            sel = SEL_STAT2;
                ADR_TXDIS:            sel = SEL_TXDIS;
                ADR_SIGDET:           sel = SEL_SIGDET;
                ADR_EXTCAP:           sel = SEL_EXTCAP;
                ADR_ALM_A, ADR_ALM_B: sel = SEL_ALARM;
                default:              sel = SEL_NONE;
            endcase
        end
    end

    // Clearing reads: status word or either alarm address
    always_comb flt_clr = reg_rd && (sel == SEL_STAT2 || sel == SEL_ALARM);

    pma_fault_latch #(.NBITS(NFLT)) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (fault_evt),
        .clr     (flt_clr),
        .flags   (flt_q)
    );

    pma_txdis_ctrl #(.LANES(LANES)) u_txdis (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr && sel == SEL_TXDIS),
        .wdata       (reg_wdata[CTL_W-1:0]),
        .tx_on       (tx_on),
        .lx4_mode    (lx4_mode),
        .dis_q       (dis_q),
        .lane_tx_en  (lane_tx_en),
        .lane_drv_en (lane_drv_en)
    );

    pma_sigdet #(.LANES(LANES)) u_sd (
        .lx4_mode (lx4_mode),
        .opt_los  (opt_los),
        .cx4_sd   (cx4_sd),
        .lane_sd  (lane_sd),
        .glob_sd  (glob_sd)
    );

    // Assemble the word of the selected register
    always_comb begin
        rd_word = '0;
        unique case (sel)
            SEL_STAT2: begin
                rd_word[CAP_LX4_BIT]  = 1'b1;
                rd_word[CAP_LOOP_BIT] = 1'b1;
                rd_word[FLT_RX_BIT]   = flt_q[0];
                rd_word[FLT_TX_BIT]   = flt_q[1];
            end
            SEL_TXDIS:  rd_word[CTL_W-1:0] = dis_q;
            SEL_SIGDET: rd_word[CTL_W-1:0] = {lane_sd, glob_sd};
            SEL_EXTCAP: rd_word[CAP_CX4_BIT] = 1'b1;
            default:    rd_word = '0;
        endcase
    end

    // Capture read data on a read strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_word;
    end

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
    // R1
    stat2_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && dev_hit && reg_addr == ADR_STAT2)
        |=> (reg_rdata & 16'hF3FF) == 16'h0011);
    // R9
    extcap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && dev_hit && reg_addr == ADR_EXTCAP) |=> reg_rdata == 16'h0001);
    // R10
    wrong_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !dev_hit) |=> reg_rdata == '0);
    // R8
    glob_sd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && dev_hit && reg_addr == ADR_SIGDET)
        |=> (reg_rdata[0] == &reg_rdata[CTL_W-1:1]) && reg_rdata[DATA_W-1:CTL_W] == '0);
    // R4
    alarm_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && dev_hit && (reg_addr == ADR_ALM_A || reg_addr == ADR_ALM_B)
         && fault_evt == '0) |=> (flt_q == '0 && reg_rdata == '0));
endmodule

// File: tb/pma_regbank_bench.sv
module pma_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_dev = 5'd1;
    logic [15:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic        lx4_mode = 1'b1;
    logic        tx_on = 1'b1;
    logic [3:0]  opt_los = '0;
    logic [3:0]  cx4_sd = '0;
    logic [1:0]  fault_evt = '0;
    logic [3:0]  lane_tx_en, lane_drv_en;
    logic [15:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    logic [4:0]  m_dis = '0;
    logic [1:0]  m_flt = '0;
    logic [15:0] m_rdata = '0;

    pma_regbank u_pma_regbank (
        .clk(clk), .rst_n(rst_n), .reg_dev(reg_dev), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .lx4_mode(lx4_mode), .tx_on(tx_on), .opt_los(opt_los), .cx4_sd(cx4_sd),
        .fault_evt(fault_evt), .lane_tx_en(lane_tx_en), .lane_drv_en(lane_drv_en),
        .reg_rdata(reg_rdata)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [4:0] dev, input logic [15:0] adr);
        logic [3:0] sd;
        sd = lx4_mode ? ~opt_los : cx4_sd;
        if (dev != 5'd1) return 16'h0;
        case (adr)
            16'h0008: return 16'h0011 | (16'(m_flt) << 10);
            16'h0009: return {11'h0, m_dis};
            16'h000A: return {11'h0, sd, &sd};
            16'h000B: return 16'h0001;
            default:  return 16'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] dev, input logic [15:0] adr);
        if (dev != 5'd1) return "R10";
        case (adr)
            16'h0008: return "R3";
            16'h0009: return "R5";
            16'h000A: return "R8";
            16'h000B: return "R9";
            16'h9003, 16'h9004: return "R4";
            default: return "R10";
        endcase
    endfunction

    // R6 / R7 lane gating against the model
    task automatic check_lanes();
        logic [3:0] ok;
        for (int n = 0; n < 4; n++) ok[n] = !m_dis[n+1] && !m_dis[0] && tx_on;
        chk("R6", {12'h0, lx4_mode ? lane_tx_en : lane_drv_en}, {12'h0, ok});
        chk("R7", {12'h0, lx4_mode ? lane_drv_en : lane_tx_en}, 16'h000F);
    endtask

    task automatic cycle(input logic rd, input logic wr, input logic [4:0] dev,
                         input logic [15:0] adr, input logic [15:0] wd, input logic [1:0] fe);
        logic [15:0] e;
        @(negedge clk);
        reg_rd = rd; reg_wr = wr; reg_dev = dev; reg_addr = adr;
        reg_wdata = wd; fault_evt = fe;
        #1;
        check_lanes();
        e = exp_read(dev, adr);
        if (rd) m_rdata = e;
        if (rd && dev == 5'd1 && (adr == 16'h0008 || adr == 16'h9003 || adr == 16'h9004))
            m_flt = '0;
        m_flt = m_flt | fe;
        if (wr && dev == 5'd1 && adr == 16'h0009) m_dis = wd[4:0];
        @(posedge clk);
        #1;
        if (rd) chk(tag_of(dev, adr), reg_rdata, e);
        else    chk("R11", reg_rdata, m_rdata);
        @(negedge clk);
        reg_rd = 0; reg_wr = 0; fault_evt = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; reg_rd = 0; reg_wr = 0; fault_evt = '0;
        repeat (2) @(posedge clk);
        #1;
        m_dis = '0; m_flt = '0; m_rdata = '0;
        chk("R12", reg_rdata, 16'h0);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin : watchdog
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'h5EED_0017);
        do_reset();
        check_lanes();
        // Reset values and fixed words
        cycle(1, 0, 1, 16'h0009, 0, 0);
        cycle(1, 0, 1, 16'h0008, 0, 0);
        chk("R1", reg_rdata & 16'hF3FF, 16'h0011);
        cycle(1, 0, 1, 16'h000B, 0, 0);
        cycle(1, 0, 1, 16'h0020, 0, 0);
        cycle(1, 0, 3, 16'h000B, 0, 0);
        // Control word, reserved bits, wrong device, read-only writes
        cycle(0, 1, 1, 16'h0009, 16'hFFFF, 0);
        cycle(1, 0, 1, 16'h0009, 0, 0);
        cycle(0, 1, 2, 16'h0009, 16'h0000, 0);
        cycle(1, 0, 1, 16'h0009, 0, 0);
        cycle(0, 1, 1, 16'h0009, 16'h0004, 0);
        tx_on = 0;
        cycle(0, 0, 1, 0, 0, 0);
        tx_on = 1;
        lx4_mode = 0;
        cycle(0, 0, 1, 0, 0, 0);
        cycle(0, 1, 1, 16'h000A, 16'hFFFF, 0);
        cycle(0, 1, 1, 16'h000B, 16'hFFFF, 0);
        cycle(0, 1, 1, 16'h0008, 16'hFFFF, 0);
        cycle(1, 0, 1, 16'h000B, 0, 0);
        cycle(1, 0, 1, 16'h0008, 0, 0);
        // Signal detect in both modes
        lx4_mode = 1; opt_los = 4'b0101;
        cycle(1, 0, 1, 16'h000A, 0, 0);
        opt_los = 4'b0000;
        cycle(1, 0, 1, 16'h000A, 0, 0);
        lx4_mode = 0; cx4_sd = 4'b1111;
        cycle(1, 0, 1, 16'h000A, 0, 0);
        cx4_sd = 4'b1110;
        cycle(1, 0, 1, 16'h000A, 0, 0);
        // Fault latch, clear on read
        cycle(0, 0, 1, 0, 0, 2'b01);
        cycle(0, 0, 1, 0, 0, 0);
        chk("R2", 16'(u_pma_regbank_dummy_read()), 16'h0);
        cycle(1, 0, 1, 16'h0008, 0, 0);
        chk("R2", reg_rdata, 16'h0411);
        cycle(1, 0, 1, 16'h0008, 0, 0);
        // Event on the same cycle as the clearing read
        cycle(0, 0, 1, 0, 0, 2'b10);
        cycle(1, 0, 1, 16'h0008, 0, 2'b10);
        cycle(1, 0, 1, 16'h0008, 0, 0);
        cycle(1, 0, 1, 16'h0008, 0, 0);
        // Alarm-address clears, including a colliding event
        cycle(0, 0, 1, 0, 0, 2'b11);
        cycle(1, 0, 1, 16'h9003, 0, 0);
        cycle(1, 0, 1, 16'h0008, 0, 0);
        cycle(0, 0, 1, 0, 0, 2'b11);
        cycle(1, 0, 1, 16'h9004, 0, 2'b01);
        cycle(1, 0, 1, 16'h0008, 0, 0);
        cycle(0, 0, 1, 0, 0, 2'b10);
        cycle(1, 0, 2, 16'h9004, 0, 0);
        cycle(1, 0, 1, 16'h0008, 0, 0);
        // Reset in the middle of a run
        cycle(0, 1, 1, 16'h0009, 16'h001F, 2'b11);
        do_reset();
        cycle(1, 0, 1, 16'h0009, 0, 0);
        cycle(1, 0, 1, 16'h0008, 0, 0);
        // Constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] adrs [7];
            logic [15:0] a;
            logic [4:0]  d;
            logic [1:0]  f;
            adrs = '{16'h0008, 16'h0009, 16'h000A, 16'h000B, 16'h9003, 16'h9004, 16'h1234};
            a = adrs[$urandom_range(0, 6)];
            d = ($urandom_range(0, 9) == 0) ? 5'd4 : 5'd1;
            f = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
            if (i % 64 == 0) lx4_mode = 1'($urandom);
            tx_on = ($urandom_range(0, 7) != 0);
            opt_los = 4'($urandom); cx4_sd = 4'($urandom);
            if ($urandom_range(0, 15) == 0) opt_los = 4'h0;
            if ($urandom_range(0, 15) == 0) cx4_sd = 4'hF;
            cycle($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, d, a,
                  16'($urandom), f);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Placeholder-free helper: a quiet cycle must not have moved read data
    function automatic logic [15:0] u_pma_regbank_dummy_read();
        return reg_rdata ^ m_rdata;
    endfunction
endmodule